// File: doc/BRIEF.md
# Quiet-Passage Gain Boost Controller

This block sits after the decimation filter of a multi-channel audio recording path. For each channel it estimates the signal level from the decimated samples. While the signal stays below a programmable trigger level, it raises an extra analog preamplifier gain in 2 dB steps, up to a programmable ceiling. Each step it adds is matched by an equal digital attenuation of the samples. The attenuation is delayed by the analog path latency, so the two gain changes cancel on the same sample and the net channel gain does not change.

Level estimation runs on the compensated samples, so it measures the input-referred level. A peak follower with an instant attack and a geometric release holds the estimate. A loud sample cuts the boost to zero on the sample that revealed it. Recovery climbs one step at a time, and each step needs a run of quiet samples. One 8-bit configuration byte is shared by all channels. It carries a threshold code in bits [7:4] and a ceiling code in bits [3:0]. Each channel also has its own enable.

Samples enter and leave as one frame of all channels on a valid/ready stream. There is a single output register. `s_ready` is high whenever that register is empty or is being emptied in the same cycle (`!m_valid || m_ready`). While `m_valid` is high and `m_ready` is low, `m_data` holds its value. The detector, the gain and the compensation delay line advance only on an accepted input frame (`s_valid && s_ready`).

Top module: `range_boost_ctrl`

## Requirements
- R1: After reset, `m_valid` is 0, all gain fields read 0, both invalid flags are 0, and the configuration is threshold code 7 with ceiling code 11.
- R2: Threshold code t (0 to 9) sets a trigger level of −12−6t dBFS, realised as the limit 2^(DW−3−t). A channel counts as quiet on an accepted frame when its updated peak is strictly below the limit.
- R3: Threshold codes 10 to 15 raise `thr_bad` one cycle after being written, and code 7 is used in their place.
- R4: Ceiling code g (0 to 14) limits the boost to g+1 steps of 2 dB. Code 15 raises `max_bad` one cycle after being written, and code 11 (12 steps) is used in its place.
- R5: The peak takes the new magnitude when that magnitude is at least the held peak. Otherwise the peak decays to p − (p >> REL_SH).
- R6: An accepted frame whose updated peak is at or above the limit sets that channel's boost to 0 at the clock edge that accepts it.
- R7: The boost rises by exactly one step after HOLD_N consecutive quiet accepted frames. It never exceeds the ceiling, and it is cut to a lowered ceiling on the next accepted frame.
- R8: The compensation step used for a frame equals the boost as it stood COMP_DLY accepted frames earlier, and it is 0 before that many frames.
- R9: A sample attenuated by k steps equals floor(x·M/2^(8+k/3)), with M = 256, 203 or 162 for k mod 3 = 0, 1 or 2.
- R10: A disabled channel reads 0 on both gain fields and passes its samples through unchanged. Its peak, boost, hold count and delay line are cleared, so it restarts from zero when enabled again.
- R11: `s_ready` equals `!m_valid || m_ready`. An accepted frame sets `m_valid`, and a stalled output keeps `m_data` stable.
- R12: Channel c uses `s_data`/`m_data` bits [DW·c+DW−1 : DW·c] (two's complement) and gain bits [4c+3 : 4c], each gain field being an unsigned count of 2 dB steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads `cfg_byte` into the configuration register |
| cfg_byte | input | 8 | Threshold code [7:4], ceiling code [3:0] |
| ch_en | input | NCH | Per-channel enable |
| s_valid | input | 1 | Input frame valid |
| s_ready | output | 1 | Input frame accepted when high with `s_valid` |
| s_data | input | NCH·DW | Input samples, one per channel |
| m_valid | output | 1 | Output frame valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | NCH·DW | Compensated samples |
| pga_gain | output | NCH·4 | Current analog boost per channel, in 2 dB steps |
| comp_gain | output | NCH·4 | Attenuation applied to the next accepted frame |
| thr_bad | output | 1 | Stored threshold code is reserved |
| max_bad | output | 1 | Stored ceiling code is reserved |

## Verification
The bench builds the block with NCH=4, DW=16, HOLD_N=3, COMP_DLY=2 and REL_SH=2. The short hold lets a channel climb to a 12- or 15-step ceiling within a few dozen frames. The fast release lets a loud burst decay and the boost recover inside one test phase. A two-frame compensation delay makes the lag between `pga_gain` and `comp_gain` visible. With a quiet boost of up to 15 steps, every residue of k mod 3 and every coarse shift up to 5 is reached. Thresholds at both ends of the code range are covered, together with random stalls and channel toggling.

// File: rtl/rbc_pkg.sv
`timescale 1ns/1ps
package rbc_pkg;
  localparam int GAIN_W = 4;
  typedef logic [GAIN_W-1:0] gain_t;

  localparam logic [3:0] THR_CODE_DFLT  = 4'd7;
  localparam logic [3:0] THR_CODE_TOP   = 4'd9;
  localparam logic [3:0] CEIL_CODE_DFLT = 4'd11;
  localparam logic [3:0] CEIL_CODE_RSVD = 4'd15;
  localparam logic [7:0] CFG_RESET      = {THR_CODE_DFLT, CEIL_CODE_DFLT};

  localparam int FRAC_W = 8;

  // Fractional part of a 2 dB multiple: 0, -2, -4 dB in Q8
  function automatic logic [FRAC_W:0] frac_gain(input logic [1:0] rem);
    case (rem)
      2'd0:    return 9'd256;
      2'd1:    return 9'd203;
      default: return 9'd162;
    endcase
  endfunction

  typedef struct packed {
    logic [3:0] thr_code;
    gain_t      ceil;
    logic       thr_bad;
    logic       ceil_bad;
  } cfg_eff_t;
endpackage

// File: rtl/rbc_cfg.sv
`timescale 1ns/1ps
module rbc_cfg
  import rbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_byte,
  output cfg_eff_t   eff
);
  logic [7:0] cfg_q;
  logic [3:0] thr_raw, ceil_raw;
  logic       thr_rsvd, ceil_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_byte;
  end

  always_comb begin
    thr_raw       = cfg_q[7:4];
    ceil_raw      = cfg_q[3:0];
    thr_rsvd      = thr_raw > THR_CODE_TOP;
    ceil_rsvd     = ceil_raw == CEIL_CODE_RSVD;
    eff.thr_bad   = thr_rsvd;
    eff.ceil_bad  = ceil_rsvd;
    eff.thr_code  = thr_rsvd ? THR_CODE_DFLT : thr_raw;
    eff.ceil      = (ceil_rsvd ? CEIL_CODE_DFLT : ceil_raw) + 4'd1;
  end
endmodule

// File: rtl/rbc_atten.sv
`timescale 1ns/1ps
module rbc_atten
  import rbc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x,
  input  gain_t                steps,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + FRAC_W + 2;

  logic [3:0]           coarse;
  logic [1:0]           fine;
  logic [FRAC_W:0]      mul;
  logic signed [PW-1:0] prod;

  always_comb begin
    coarse = steps / 4'd3;
    fine   = 2'(steps % 4'd3);
    mul    = frac_gain(fine);
    prod   = PW'(x) * PW'($signed({1'b0, mul}));
    // 6 dB per coarse step as an arithmetic shift; attenuation cannot overflow
    y      = DW'(prod >>> (FRAC_W + int'(coarse)));
  end
endmodule

// File: rtl/rbc_chan.sv
`timescale 1ns/1ps
module rbc_chan
  import rbc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int HOLD_N   = 4,
  parameter int COMP_DLY = 2,
  parameter int REL_SH   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 take,
  input  logic signed [DW-1:0] x,
  input  logic [3:0]           thr_code,
  input  gain_t                ceil,
  output logic signed [DW-1:0] y,
  output gain_t                pga,
  output gain_t                comp
);
  localparam int            HW        = (HOLD_N > 1) ? $clog2(HOLD_N) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_N - 1);
  localparam logic [DW-1:0] LIM_ONE   = DW'(1);

  gain_t         gain_q, comp_tap, comp_use;
  logic [HW-1:0] hold_q;
  logic [DW-1:0] peak_q, peak_nxt, mag, lim;
  logic          below;

  generate
    if (COMP_DLY == 0) begin : g_nodly
      assign comp_tap = gain_q;
    end else begin : g_dly
      gain_t line_q [COMP_DLY];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < COMP_DLY; i++) line_q[i] <= '0;
        end else if (!en) begin
          for (int i = 0; i < COMP_DLY; i++) line_q[i] <= '0;
        end else if (take) begin
          line_q[0] <= gain_q;
          for (int i = 1; i < COMP_DLY; i++) line_q[i] <= line_q[i-1];
        end
      end
      assign comp_tap = line_q[COMP_DLY-1];
    end
  endgenerate

  assign comp_use = en ? comp_tap : '0;

  rbc_atten #(.DW(DW)) u_atten (
    .x     (x),
    .steps (comp_use),
    .y     (y)
  );

  always_comb begin
    mag      = y[DW-1] ? DW'(-y) : DW'(y);
    peak_nxt = (mag >= peak_q) ? mag : peak_q - (peak_q >> REL_SH);
    lim      = LIM_ONE << (DW - 3 - int'(thr_code));
    below    = peak_nxt < lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      hold_q <= '0;
      peak_q <= '0;
    end else if (!en) begin
      gain_q <= '0;
      hold_q <= '0;
      peak_q <= '0;
    end else if (take) begin
      peak_q <= peak_nxt;
      if (!below) begin
        gain_q <= '0;
        hold_q <= '0;
      end else if (gain_q >= ceil) begin
        gain_q <= ceil;
        hold_q <= '0;
      end else if (hold_q == HOLD_LAST) begin
        gain_q <= gain_q + 1'b1;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign pga  = en ? gain_q : '0;
  assign comp = comp_use;
endmodule

// File: rtl/range_boost_ctrl.sv
`timescale 1ns/1ps
module range_boost_ctrl
  import rbc_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 16,
  parameter int HOLD_N   = 4800,
  parameter int COMP_DLY = 4,
  parameter int REL_SH   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_byte,
  input  logic [NCH-1:0]        ch_en,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [NCH*DW-1:0]     s_data,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [NCH*DW-1:0]     m_data,
  output logic [NCH*GAIN_W-1:0] pga_gain,
  output logic [NCH*GAIN_W-1:0] comp_gain,
  output logic                  thr_bad,
  output logic                  max_bad
);
  cfg_eff_t          eff;
  logic              take;
  logic              m_valid_q;
  logic [NCH*DW-1:0] y_bus, m_data_q;

  rbc_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_byte (cfg_byte),
    .eff      (eff)
  );

  assign s_ready = !m_valid_q || m_ready;
  assign take    = s_valid && s_ready;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [DW-1:0] y_c;
      gain_t                pga_c, comp_c;
      rbc_chan #(
        .DW       (DW),
        .HOLD_N   (HOLD_N),
        .COMP_DLY (COMP_DLY),
        .REL_SH   (REL_SH)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en[c]),
        .take     (take),
        .x        (s_data[c*DW +: DW]),
        .thr_code (eff.thr_code),
        .ceil     (eff.ceil),
        .y        (y_c),
        .pga      (pga_c),
        .comp     (comp_c)
      );
      assign y_bus[c*DW +: DW]             = y_c;
      assign pga_gain[c*GAIN_W +: GAIN_W]  = pga_c;
      assign comp_gain[c*GAIN_W +: GAIN_W] = comp_c;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
    end else if (take) begin
      m_valid_q <= 1'b1;
      m_data_q  <= y_bus;
    end else if (m_ready) begin
      m_valid_q <= 1'b0;
    end
  end

  assign m_valid = m_valid_q;
  assign m_data  = m_data_q;
  assign thr_bad = eff.thr_bad;
  assign max_bad = eff.ceil_bad;
endmodule

// File: rtl/range_boost_ctrl_chk.sv
`timescale 1ns/1ps
module range_boost_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_byte,
  input logic [NCH-1:0]    ch_en,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [NCH*DW-1:0] m_data,
  input logic [NCH*4-1:0]  pga_gain,
  input logic [NCH*4-1:0]  comp_gain,
  input logic              thr_bad,
  input logic              max_bad
);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  assert_accept_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);

  assert_thr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_byte[7:4] > 4'd9) |=> thr_bad);

  assert_max_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_byte[3:0] == 4'd15) |=> max_bad);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pga_gain[c*4 +: 4] > $past(pga_gain[c*4 +: 4])
        |-> pga_gain[c*4 +: 4] == $past(pga_gain[c*4 +: 4]) + 4'd1);

      assert_comp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en[c] && $past(ch_en[c]) && !$past(s_valid && s_ready)
        |-> $stable(comp_gain[c*4 +: 4]));

      assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_en[c]) |-> pga_gain[c*4 +: 4] == 4'd0 && comp_gain[c*4 +: 4] == 4'd0);
    end
  endgenerate
endmodule

bind range_boost_ctrl range_boost_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_byte  (cfg_byte),
  .ch_en     (ch_en),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .pga_gain  (pga_gain),
  .comp_gain (comp_gain),
  .thr_bad   (thr_bad),
  .max_bad   (max_bad)
);

// File: tb/range_boost_ctrl_tb_top.sv
`timescale 1ns/1ps
module range_boost_ctrl_tb_top;
  localparam int NCH = 4, DW = 16, HOLD_N = 3, COMP_DLY = 2, REL_SH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, cfg_we, s_valid, m_ready;
  logic [7:0]        cfg_byte;
  logic [NCH-1:0]    ch_en;
  logic [NCH*DW-1:0] s_data;
  logic              s_ready, m_valid, thr_bad, max_bad;
  logic [NCH*DW-1:0] m_data;
  logic [NCH*4-1:0]  pga_gain, comp_gain;

  int x_in [NCH];
  always_comb for (int c = 0; c < NCH; c++) s_data[c*DW +: DW] = DW'(x_in[c]);

  range_boost_ctrl #(.NCH(NCH), .DW(DW), .HOLD_N(HOLD_N), .COMP_DLY(COMP_DLY), .REL_SH(REL_SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_byte(cfg_byte), .ch_en(ch_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .pga_gain(pga_gain), .comp_gain(comp_gain), .thr_bad(thr_bad), .max_bad(max_bad));

  int n_cmp = 0, n_bad = 0;

  // Reference model state
  int   r_peak [NCH], r_gain [NCH], r_hold [NCH], r_out [NCH];
  int   r_line [NCH][COMP_DLY];
  bit   r_mv;
  logic [7:0] r_cfg;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int thr_eff();
    return (r_cfg[7:4] > 4'd9) ? 7 : int'(r_cfg[7:4]);
  endfunction
  function automatic int ceil_eff();
    return (r_cfg[3:0] == 4'd15) ? 12 : int'(r_cfg[3:0]) + 1;
  endfunction
  // R9: floor(x * M / 2^(8 + k/3))
  function automatic int attn(int x, int k);
    longint m;
    case (k % 3)
      0: m = 256;
      1: m = 203;
      default: m = 162;
    endcase
    return int'((longint'(x) * m) >>> (8 + k / 3));
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      r_peak[c] = 0; r_gain[c] = 0; r_hold[c] = 0; r_out[c] = 0;
      for (int i = 0; i < COMP_DLY; i++) r_line[c][i] = 0;
    end
    r_mv = 0;
    r_cfg = 8'h7B;
  endtask

  task automatic model_edge();
    bit take;
    take = s_valid && (!r_mv || m_ready);
    for (int c = 0; c < NCH; c++) begin
      if (!ch_en[c]) begin
        r_peak[c] = 0; r_gain[c] = 0; r_hold[c] = 0;
        for (int i = 0; i < COMP_DLY; i++) r_line[c][i] = 0;
        if (take) r_out[c] = x_in[c];
      end else if (take) begin
        int y, mg, pk, lim;
        y  = attn(x_in[c], r_line[c][COMP_DLY-1]);
        mg = (y < 0) ? -y : y;
        pk = (mg >= r_peak[c]) ? mg : r_peak[c] - (r_peak[c] >> REL_SH);
        lim = 1 << (DW - 3 - thr_eff());
        for (int i = COMP_DLY - 1; i > 0; i--) r_line[c][i] = r_line[c][i-1];
        r_line[c][0] = r_gain[c];
        r_peak[c] = pk;
        if (pk >= lim) begin r_gain[c] = 0; r_hold[c] = 0; end
        else if (r_gain[c] >= ceil_eff()) begin r_gain[c] = ceil_eff(); r_hold[c] = 0; end
        else if (r_hold[c] == HOLD_N - 1) begin r_gain[c]++; r_hold[c] = 0; end
        else r_hold[c]++;
        r_out[c] = y;
      end
    end
    if (take) r_mv = 1;
    else if (m_ready) r_mv = 0;
    if (cfg_we) r_cfg = cfg_byte;
  endtask

  task automatic compare_all();
    chk("R11", "s_ready", s_ready, (!r_mv || m_ready));
    chk("R11", "m_valid", m_valid, r_mv);
    chk("R3", "thr_bad", thr_bad, (r_cfg[7:4] > 4'd9));
    chk("R4", "max_bad", max_bad, (r_cfg[3:0] == 4'd15));
    for (int c = 0; c < NCH; c++) begin
      // R12: field positions per channel
      chk("R7", $sformatf("pga ch%0d", c), pga_gain[c*4 +: 4], ch_en[c] ? r_gain[c] : 0);
      chk("R8", $sformatf("comp ch%0d", c), comp_gain[c*4 +: 4], ch_en[c] ? r_line[c][COMP_DLY-1] : 0);
      if (r_mv) chk("R9", $sformatf("m_data ch%0d", c), $signed(m_data[c*DW +: DW]), r_out[c]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    cfg_we = 1'b0;
  endtask

  task automatic run_quiet(int n, int amp);
    for (int k = 0; k < n; k++) begin
      s_valid = 1'b1; m_ready = 1'b1;
      for (int c = 0; c < NCH; c++) x_in[c] = int'($urandom_range(0, 2 * amp)) - amp;
      tick();
    end
  endtask

  task automatic run_random(int n, int amp);
    for (int k = 0; k < n; k++) begin
      s_valid = ($urandom_range(0, 3) != 0);
      m_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) ch_en[$urandom_range(0, NCH-1)] ^= 1'b1;
      for (int c = 0; c < NCH; c++) x_in[c] = int'($urandom_range(0, 2 * amp)) - amp;
      tick();
    end
  endtask

  task automatic set_cfg(logic [7:0] v);
    cfg_byte = v; cfg_we = 1'b1; s_valid = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_byte = 8'h00; s_valid = 1'b0; m_ready = 1'b1;
    ch_en = '1;
    for (int c = 0; c < NCH; c++) x_in[c] = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "m_valid after reset", m_valid, 0);
    chk("R1", "pga_gain after reset", pga_gain, 0);
    chk("R1", "comp_gain after reset", comp_gain, 0);
    chk("R1", "flags after reset", {thr_bad, max_bad}, 0);
    compare_all();

    // Default config: quiet input climbs to 12 steps
    run_quiet(45, 40);
    chk("R7", "default ceiling ch1", pga_gain[7:4], 12);
    chk("R8", "comp caught up ch1", comp_gain[7:4], 12);
    x_in[1] = -1001; tick();
    chk("R9", "12-step attenuation of -1001", $signed(m_data[1*DW +: DW]), -63);

    // Loud sample on ch0
    x_in[0] = 20000; x_in[1] = 5; x_in[2] = 5; x_in[3] = 5; tick();
    chk("R6", "ch0 boost cut on loud sample", pga_gain[3:0], 0);
    chk("R8", "ch0 comp still delayed", comp_gain[3:0], 12);
    run_quiet(70, 40);
    chk("R5", "ch0 recovers after peak release", pga_gain[3:0], 12);

    // Threshold boundary on ch3: code 3, limit 1024, ceiling 15
    set_cfg(8'h3E);
    ch_en[3] = 1'b0; s_valid = 1'b1; x_in[3] = -5000; tick();
    chk("R10", "disabled ch3 passthrough", $signed(m_data[3*DW +: DW]), -5000);
    chk("R10", "disabled ch3 gains", {pga_gain[15:12], comp_gain[15:12]}, 0);
    ch_en[3] = 1'b1;
    for (int k = 0; k < 5; k++) begin x_in[3] = 1023; tick(); end
    chk("R2", "1023 below limit 1024 gives boost", pga_gain[15:12], 1);
    x_in[3] = 1000; tick();
    chk("R9", "one-step attenuation of 1000", $signed(m_data[3*DW +: DW]), 792);
    ch_en[3] = 1'b0; tick(); ch_en[3] = 1'b1;
    for (int k = 0; k < 3; k++) begin x_in[3] = 1024; tick(); end
    chk("R2", "1024 at limit gives no boost", pga_gain[15:12], 0);

    // Reserved codes
    set_cfg(8'hAF);
    chk("R3", "thr_bad for code 10", thr_bad, 1);
    chk("R4", "max_bad for code 15", max_bad, 1);
    run_quiet(50, 20);
    chk("R4", "reserved ceiling falls back to 12", pga_gain[7:4], 12);

    // Deepest threshold, widest ceiling
    set_cfg(8'h9E);
    run_quiet(60, 8);
    chk("R4", "ceiling code 14 gives 15 steps", pga_gain[11:8], 15);
    set_cfg(8'h91);
    run_quiet(1, 8);
    chk("R7", "clamp to lowered ceiling", pga_gain[11:8], 2);

    // Randomised stream with stalls and channel toggles
    set_cfg(8'h02);
    run_random(600, 12000);
    set_cfg(8'h55);
    run_random(600, 600);
    chk("R12", "ch3 gain field", pga_gain[15:12], ch_en[3] ? r_gain[3] : 0);
    finish_run();
  end
endmodule